// File: doc/BRIEF.md
# Modulation LFO for a Sample-Playback Voice

This block is the low-frequency oscillator of one playback voice. It advances on a sample tick and produces two modulation results from a single shared phase. The first is the voice's phase increment with vibrato applied, so it can swing above and below the base increment. The second is an attenuation offset for tremolo, which only ever adds attenuation. The pitch path and the amplitude path each have their own waveform select and depth, and each waveform can be a sawtooth, a square, a triangle or pseudo-random noise.

The oscillator period comes from a fixed table of 32 irregular sample counts, selected by a 5-bit rate code. The phase only goes back to zero when a loop-start strobe arrives while the phase-reset enable is set. Starting a note does not touch the phase. Both outputs are registered and feed the voice's pitch accumulator and its attenuation adder.

Top module: `mod_lfo`

## Requirements
- R1: While `rst` is high, both outputs are 0 and the phase is cleared. After reset the phase ramp starts at position 0.
- R2: The period in samples for each rate code is a table value. All table values are multiples of 256. Examples: code 0x1F gives 0x100, 0x1E gives 0x200, 0x1C gives 0x400, 0x1A gives 0x800, 0x10 gives 0x3C00, 0x0A gives 0xDC00, 0x08 gives 0xFC00, and 0x00 gives 0x3FC00. An 8-bit ramp r advances by one after every period/256 ticks and wraps from 255 to 0 after exactly one period.
- R3: With pitch depth 0, the pitch output equals the base increment. With depth d from 1 to 7, the output is base + floor(base*s / 2^(17-d)), where s is the signed 8-bit pitch waveform value. The full swing is therefore about base>>(10-d).
- R4: Pitch waveform codes: 0 is a sawtooth, with s equal to r read as two's complement (starting at mid value and rising). 1 is a square, with s = 127 for r<128 and -128 otherwise. 2 is a triangle, with s = 2r for r<64 or r>=192 and s = ~(2r) otherwise (starting at mid value and rising first). 3 is noise. All values are taken modulo 256.
- R5: With amplitude depth 0, the attenuation output is 0. With depth d from 1 to 7, the output is floor(u * 2^(d+2) / 256), where u is a 9-bit level from 0 to 256. The output never exceeds 0x200 (d=7), and d=1 reaches at most 0x008.
- R6: Amplitude waveform codes: 0 is a sawtooth with u = r. 1 is a square with u = 0 for r<128 and u = 256 otherwise. 2 is a triangle clamped at zero: u = 0 for r<128, u = 4(r-128) for 128<=r<192, and u = 4(256-r) otherwise. 3 is noise.
- R7: Noise comes from a 16-bit maximal-length LFSR that advances once per tick. Its state is never zero. Its low byte is used as r for both paths, so noise values change from sample to sample.
- R8: A high `loop_start` while `phase_reset_en` is high clears the phase at that edge. A loop start while the enable is low has no effect. Without a tick the phase holds.
- R9: Each output is registered. It reflects the phase, the waveform and depth inputs and the base increment of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sample strobe |
| rate_code | input | 5 | Selects the oscillator period |
| pitch_wave | input | 2 | Pitch waveform select |
| pitch_depth | input | 3 | Pitch modulation depth, 0 disables |
| amp_wave | input | 2 | Amplitude waveform select |
| amp_depth | input | 3 | Amplitude modulation depth, 0 disables |
| phase_reset_en | input | 1 | Allows loop starts to clear the phase |
| loop_start | input | 1 | Strobe marking a sample-loop start |
| base_inc | input | INC_W | Unmodulated phase increment of the voice |
| pitch_inc | output | INC_W+2 | Signed modulated phase increment |
| amp_atten | output | 10 | Added attenuation, 0 to 0x200 |

## Verification
The assertions check the cycle-level rules on every clock. A clear always leaves the ramp at zero, the ramp holds without a tick and moves by at most one step per tick, the noise register never locks at zero, and a zero depth passes the base through or gives zero attenuation. The attenuation upper bound is also checked on every clock. The exact shape values, the period table entries and the wrap after one full period can only be shown by the bench scenarios. Those scenarios clear the phase, apply a known number of ticks and compare both outputs against values computed from the formulas.

// File: rtl/mod_lfo_pkg.sv
package mod_lfo_pkg;
  localparam int RAMP_W = 8;
  localparam int SUB_W  = 10;
  localparam int ATT_W  = RAMP_W + 2;
  localparam int LVL_W  = RAMP_W + 1;

  typedef enum logic [1:0] {
    WAVE_SAW    = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_TRI    = 2'd2,
    WAVE_NOISE  = 2'd3
  } wave_e;

  // samples per ramp step = table period / 256
  function automatic logic [SUB_W-1:0] step_len(input logic [4:0] code);
    case (code)
      5'h00: step_len = 10'h3FC;  5'h01: step_len = 10'h37C;
      5'h02: step_len = 10'h2FC;  5'h03: step_len = 10'h27C;
      5'h04: step_len = 10'h1FC;  5'h05: step_len = 10'h1BC;
      5'h06: step_len = 10'h17C;  5'h07: step_len = 10'h13C;
      5'h08: step_len = 10'h0FC;  5'h09: step_len = 10'h0BC;
      5'h0A: step_len = 10'h0DC;  5'h0B: step_len = 10'h09C;
      5'h0C: step_len = 10'h07C;  5'h0D: step_len = 10'h06C;
      5'h0E: step_len = 10'h05C;  5'h0F: step_len = 10'h04C;
      5'h10: step_len = 10'h03C;  5'h11: step_len = 10'h034;
      5'h12: step_len = 10'h02C;  5'h13: step_len = 10'h024;
      5'h14: step_len = 10'h01C;  5'h15: step_len = 10'h018;
      5'h16: step_len = 10'h014;  5'h17: step_len = 10'h010;
      5'h18: step_len = 10'h00C;  5'h19: step_len = 10'h00A;
      5'h1A: step_len = 10'h008;  5'h1B: step_len = 10'h006;
      5'h1C: step_len = 10'h004;  5'h1D: step_len = 10'h003;
      5'h1E: step_len = 10'h002;  default: step_len = 10'h001;
    endcase
  endfunction
endpackage

// File: rtl/lfo_phase.sv
module lfo_phase
  import mod_lfo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clear,
  input  logic [4:0]        rate_code,
  output logic [RAMP_W-1:0] ramp
);
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] last_sub;

  assign last_sub = step_len(rate_code) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sub  <= '0;
      ramp <= '0;
    end else if (tick) begin
      if (sub >= last_sub) begin
        sub  <= '0;
        ramp <= ramp + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ramp == '0));
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!clear && !tick) |=> $stable(ramp));
  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !clear) |=> (ramp == $past(ramp) || ramp == RAMP_W'($past(ramp) + 1'b1)));
endmodule

// File: rtl/lfo_noise.sv
module lfo_noise #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter int          OUT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [OUT_W-1:0] noise
);
  logic [LFSR_W-1:0] state;
  logic              fb;

  assign fb    = ^(state & TAPS[LFSR_W-1:0]);
  assign noise = state[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED[LFSR_W-1:0];
    else if (tick) state <= {state[LFSR_W-2:0], fb};
  end

  p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/lfo_shape.sv
module lfo_shape
  import mod_lfo_pkg::*;
#(
  parameter int INC_W = 20
) (
  input  logic [RAMP_W-1:0]       ramp,
  input  logic [RAMP_W-1:0]       noise,
  input  logic [1:0]              pitch_wave,
  input  logic [2:0]              pitch_depth,
  input  logic [1:0]              amp_wave,
  input  logic [2:0]              amp_depth,
  input  logic [INC_W-1:0]        base_inc,
  output logic signed [INC_W+1:0] pitch_next,
  output logic [ATT_W-1:0]        atten_next
);
  localparam int PROD_W = INC_W + RAMP_W + 1;

  logic [RAMP_W-1:0]        dbl;
  logic [RAMP_W-1:0]        s_bits;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic [4:0]               shamt;
  logic [LVL_W-1:0]         lvl;
  logic [6:0]               fall;
  logic [17:0]              scaled;

  assign dbl  = {ramp[RAMP_W-2:0], 1'b0};
  assign fall = 7'd64 - {1'b0, ramp[5:0]};

  always_comb begin
    case (wave_e'(pitch_wave))
      WAVE_SAW:    s_bits = ramp;
      WAVE_SQUARE: s_bits = ramp[RAMP_W-1] ? 8'h80 : 8'h7F;
      WAVE_TRI:    s_bits = (ramp[7] ^ ramp[6]) ? ~dbl : dbl;
      default:     s_bits = noise;
    endcase
  end

  assign shamt   = 5'd17 - {2'b00, pitch_depth};
  assign prod    = $signed({1'b0, base_inc}) * $signed(s_bits);
  assign shifted = prod >>> shamt;

  always_comb begin
    if (pitch_depth == 3'd0)
      pitch_next = $signed({2'b00, base_inc});
    else
      pitch_next = $signed({2'b00, base_inc}) + $signed(shifted[INC_W+1:0]);
  end

  always_comb begin
    case (wave_e'(amp_wave))
      WAVE_SAW:    lvl = {1'b0, ramp};
      WAVE_SQUARE: lvl = ramp[7] ? 9'd256 : 9'd0;
      WAVE_TRI:    lvl = !ramp[7] ? 9'd0 : (!ramp[6] ? {1'b0, ramp[5:0], 2'b00} : {fall, 2'b00});
      default:     lvl = {1'b0, noise};
    endcase
  end

  assign scaled = {9'd0, lvl} << ({2'b00, amp_depth} + 5'd2);

  always_comb begin
    if (amp_depth == 3'd0) atten_next = '0;
    else                   atten_next = scaled[ATT_W+7:8];
  end
endmodule

// File: rtl/mod_lfo.sv
module mod_lfo
  import mod_lfo_pkg::*;
#(
  parameter int INC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [4:0]              rate_code,
  input  logic [1:0]              pitch_wave,
  input  logic [2:0]              pitch_depth,
  input  logic [1:0]              amp_wave,
  input  logic [2:0]              amp_depth,
  input  logic                    phase_reset_en,
  input  logic                    loop_start,
  input  logic [INC_W-1:0]        base_inc,
  output logic signed [INC_W+1:0] pitch_inc,
  output logic [ATT_W-1:0]        amp_atten
);
  logic                    clear;
  logic [RAMP_W-1:0]       ramp;
  logic [RAMP_W-1:0]       noise;
  logic signed [INC_W+1:0] pitch_next;
  logic [ATT_W-1:0]        atten_next;

  assign clear = loop_start && phase_reset_en;

  lfo_phase u_phase (
    .clk(clk), .rst(rst), .tick(tick), .clear(clear),
    .rate_code(rate_code), .ramp(ramp)
  );

  lfo_noise #(.OUT_W(RAMP_W)) u_noise (
    .clk(clk), .rst(rst), .tick(tick), .noise(noise)
  );

  lfo_shape #(.INC_W(INC_W)) u_shape (
    .ramp(ramp), .noise(noise),
    .pitch_wave(pitch_wave), .pitch_depth(pitch_depth),
    .amp_wave(amp_wave), .amp_depth(amp_depth),
    .base_inc(base_inc),
    .pitch_next(pitch_next), .atten_next(atten_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pitch_inc <= '0;
      amp_atten <= '0;
    end else begin
      pitch_inc <= pitch_next;
      amp_atten <= atten_next;
    end
  end

  p_amp_off_r5: assert property (@(posedge clk) disable iff (rst)
    (amp_depth == 3'd0) |=> (amp_atten == '0));
  p_amp_bound_r5: assert property (@(posedge clk) disable iff (rst)
    amp_atten <= ATT_W'(10'h200));
  p_pitch_off_r3: assert property (@(posedge clk) disable iff (rst)
    (pitch_depth == 3'd0) |=> (pitch_inc == $signed({2'b00, $past(base_inc)})));
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pitch_inc == '0 && amp_atten == '0));
endmodule

// File: tb/mod_lfo_test.sv
module mod_lfo_test;
  localparam int CLK_PERIOD = 10;
  localparam int INC_W = 20;

  typedef struct packed {
    logic [4:0]  fc;
    logic [1:0]  pw;
    logic [2:0]  pd;
    logic [1:0]  aw;
    logic [2:0]  ad;
    logic [19:0] base;
    logic [31:0] n;
    logic [31:0] exp_p;
    logic [31:0] exp_a;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'h1F, 2'd0, 3'd7, 2'd0, 3'd7, 20'h40000, 32'd64,    32'h44000, 32'h080}, // R4 R6 saw
    '{5'h1F, 2'd1, 3'd7, 2'd1, 3'd7, 20'h40000, 32'd200,   32'h38000, 32'h200}, // R4 R6 square low/max
    '{5'h1F, 2'd1, 3'd7, 2'd1, 3'd7, 20'h40000, 32'd10,    32'h47F00, 32'h000}, // R4 R6 square first half
    '{5'h1F, 2'd2, 3'd4, 2'd2, 3'd4, 20'h40000, 32'd32,    32'h40800, 32'h000}, // R4 R6 tri rising/clamped
    '{5'h1F, 2'd2, 3'd4, 2'd2, 3'd4, 20'h40000, 32'd160,   32'h3F7E0, 32'h020}, // R4 R6 tri falling
    '{5'h1F, 2'd2, 3'd4, 2'd2, 3'd4, 20'h40000, 32'd224,   32'h3F800, 32'h020}, // R4 R6 tri last quarter
    '{5'h1F, 2'd0, 3'd1, 2'd0, 3'd1, 20'h40000, 32'd255,   32'h3FFFC, 32'h007}, // R3 R5 depth 1
    '{5'h1F, 2'd0, 3'd0, 2'd0, 3'd0, 20'h40000, 32'd100,   32'h40000, 32'h000}, // R3 R5 depth 0
    '{5'h1C, 2'd0, 3'd7, 2'd0, 3'd7, 20'h40000, 32'd400,   32'h46400, 32'h0C8}, // R2 code 0x1C
    '{5'h1E, 2'd0, 3'd7, 2'd0, 3'd7, 20'h40000, 32'd301,   32'h39600, 32'h12C}, // R2 code 0x1E
    '{5'h1F, 2'd1, 3'd3, 2'd0, 3'd3, 20'h12345, 32'd0,     32'h12586, 32'h000}, // R3 odd base
    '{5'h10, 2'd0, 3'd7, 2'd0, 3'd0, 20'h40000, 32'd15359, 32'h3FF00, 32'h000}, // R2 end of period
    '{5'h10, 2'd0, 3'd7, 2'd0, 3'd0, 20'h40000, 32'd15360, 32'h40000, 32'h000}, // R2 wrap
    '{5'h0A, 2'd0, 3'd7, 2'd0, 3'd0, 20'h40000, 32'd2200,  32'h40A00, 32'h000}  // R2 irregular entry
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [4:0] rate_code = 5'h1F;
  logic [1:0] pitch_wave = 2'd0;
  logic [2:0] pitch_depth = 3'd7;
  logic [1:0] amp_wave = 2'd0;
  logic [2:0] amp_depth = 3'd7;
  logic phase_reset_en = 1'b0;
  logic loop_start = 1'b0;
  logic [INC_W-1:0] base_inc = 20'h40000;
  logic signed [INC_W+1:0] pitch_inc;
  logic [9:0] amp_atten;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_lfo #(.INC_W(INC_W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
    .pitch_wave(pitch_wave), .pitch_depth(pitch_depth),
    .amp_wave(amp_wave), .amp_depth(amp_depth),
    .phase_reset_en(phase_reset_en), .loop_start(loop_start),
    .base_inc(base_inc), .pitch_inc(pitch_inc), .amp_atten(amp_atten)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    rate_code = v.fc; pitch_wave = v.pw; pitch_depth = v.pd;
    amp_wave = v.aw; amp_depth = v.ad; base_inc = v.base;
    phase_reset_en = 1'b1; loop_start = 1'b1; tick = 1'b0;
    @(negedge clk);
    loop_start = 1'b0; tick = 1'b1;
    repeat (v.n) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pitch in reset", 32'(unsigned'(pitch_inc)), 32'h0);
    check("R1 atten in reset", 32'(amp_atten), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 phase starts at zero", 32'(unsigned'(pitch_inc)), 32'h40000);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i]);
      check($sformatf("R2/R3/R4 pitch vector %0d", i), 32'(unsigned'(pitch_inc)), VECS[i].exp_p);
      check($sformatf("R5/R6 atten vector %0d", i), 32'(amp_atten), VECS[i].exp_a);
    end

    // R8: loop start without enable leaves phase alone
    run(VECS[0]);
    phase_reset_en = 1'b0; loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
    @(negedge clk);
    check("R8 disabled loop start ignored", 32'(unsigned'(pitch_inc)), 32'h44000);
    // R9: depth change shows after one edge
    pitch_depth = 3'd0;
    #1;
    check("R9 output still registered", 32'(unsigned'(pitch_inc)), 32'h44000);
    @(negedge clk);
    check("R9 output after one edge", 32'(unsigned'(pitch_inc)), 32'h40000);
    pitch_depth = 3'd7;
    // R8: enabled loop start clears
    phase_reset_en = 1'b1; loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
    @(negedge clk);
    check("R8 enabled loop start clears", 32'(unsigned'(pitch_inc)), 32'h40000);

    // R7: noise on both paths
    begin
      int changes = 0;
      int out_of_range = 0;
      logic [9:0] prev;
      pitch_wave = 2'd3; amp_wave = 2'd3; amp_depth = 3'd7; pitch_depth = 3'd7;
      tick = 1'b1;
      @(negedge clk);
      @(negedge clk);
      prev = amp_atten;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        if (amp_atten != prev) changes++;
        if (amp_atten > 10'h200) out_of_range++;
        if (pitch_inc < 22'sh38000 || pitch_inc > 22'sh48000) out_of_range++;
        prev = amp_atten;
      end
      tick = 1'b0;
      check("R7 noise values vary", 32'(changes >= 8), 32'd1);
      check("R7 noise within range", 32'(out_of_range), 32'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule